// File: doc/BRIEF.md
# Clock and Reset Control Register

This block is the control and status register of a clock and power management unit. It has a single write port and a read port. It tracks whether the system PLL is in lock, both as a live flag and as a sticky record of any lock loss that software did not cause. It collects timer wake-up and timer-interrupt events into write-one-to-clear flags. It picks the high- or low-frequency clock divider, and it drives a power-switch pin that external supply circuitry uses in deep-sleep.

It also raises a one-cycle hard-reset request when the PLL loses lock, if that reset source is enabled. It does the same when the processor signals checkstop, if that source is enabled and debug mode was not active at reset. Three reset inputs form a hierarchy: power-on implies hard, and hard implies soft. Each register field is returned to its default only by the reset domains that own it.

Top module: `ccr_ctrl_reg`

## Requirements
- R1: Read bit 0 shows the PLL lock input as sampled at the last clock edge: 1 while locked, 0 while not.
- R2: Read bit 1, the sticky loss flag, sets when the lock input falls while the software-loss qualifier is low. A fall with the qualifier high leaves it unchanged.
- R3: The sticky loss flag is cleared only by power-on reset or by writing 1 to bit 1. Hard reset and writing 0 leave it unchanged, and a loss in the same cycle as a clearing write leaves it set.
- R4: Read bit 2, the wake-up flag, sets on any bit of the timer-expiry input. Writing 1 clears it, and both power-on and hard reset set it.
- R5: When the mode field (bits 6:5) is 2'b11 and the clock-source bit is 0, the power-switch output equals the wake-up flag. In every other setting the output is 1.
- R6: Read bit 3, the timer-interrupt flag, sets on any bit of the timer-interrupt input, and it stays set if a clearing write arrives in the same cycle. Writing 1 clears it, and power-on or hard reset clears it.
- R7: The divider select output is 1 (low-frequency divider) only when the clock-source bit (bit 4) is 1 and the timer-interrupt flag is 0.
- R8: Hard reset clears the clock-source bit, the mode field, the lock bit, the lock-loss reset enable and the checkstop reset enable.
- R9: The checkstop reset enable (bit 8) takes only the first write after a soft or harder reset. A checkstop pulse while it is 1 raises the reset request unless debug enable was high at the last hard reset.
- R10: While the lock-loss reset enable (bit 9) is 1, a lock loss that software did not cause raises the hard-reset request for one cycle.
- R11: Writing 1 to the lock bit (bit 7) sets it. While it is set, writes do not change the mode field or the clock-source bit, and only hard reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| hard_rst_i | input | 1 | Synchronous hard reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register read value |
| pll_lock_i | input | 1 | PLL lock indication |
| sw_lol_i | input | 1 | Current lock loss is software-initiated |
| tmr_exp_i | input | 4 | Timer expiry and alarm pulses |
| tmr_irq_i | input | 4 | Timer interrupt pulses |
| chkstop_i | input | 1 | Processor checkstop pulse |
| dbg_en_i | input | 1 | Debug mode enable, sampled at reset |
| div_sel_o | output | 1 | 1 selects the low-frequency divider |
| pwr_sw_o | output | 1 | Power-switch pin |
| hrst_req_o | output | 1 | Hard-reset request pulse |

## Verification
Every register result is due exactly one clock edge after its stimulus. This covers a flag set by an event, a write, a cleared or protected field, and a reset request. The divider select and power-switch outputs are combinational from those registers, so they also settle one edge after the stimulus. The bench drives each stimulus at a falling edge, lets one rising edge pass, and compares all outputs at the next falling edge before it drives anything new. Reset effects are compared at the first falling edge after the reset input is released.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_TMR  = 4;
  localparam int unsigned NUM_STAT = 3;
  // read/write bit positions
  localparam int unsigned B_LIVE   = 0;
  localparam int unsigned B_LOST   = 1;
  localparam int unsigned B_WAKE   = 2;
  localparam int unsigned B_TIRQ   = 3;
  localparam int unsigned B_CSRC   = 4;
  localparam int unsigned B_MODE   = 5;
  localparam int unsigned B_LOCK   = 7;
  localparam int unsigned B_CSEN   = 8;
  localparam int unsigned B_LOLEN  = 9;
  localparam logic [1:0]  MODE_DEEP = 2'b11;
  // status index: 0 lost, 1 wake, 2 tirq
  localparam logic [NUM_STAT-1:0] STAT_RST_VAL = 3'b010;
  localparam logic [NUM_STAT-1:0] STAT_HARD    = 3'b110;
endpackage

// File: rtl/ccr_w1c_bit.sv
module ccr_w1c_bit #(
  parameter logic RST_VAL = 1'b0,
  parameter logic HARD_DOM = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   q_o <= RST_VAL;
    else if (HARD_DOM && hard_rst_i) q_o <= RST_VAL;
    else if (set_i)                q_o <= 1'b1;
    else if (clr_i)                q_o <= 1'b0;
  end
endmodule

// File: rtl/ccr_lock_mon.sv
module ccr_lock_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_lock_i,
  input  logic sw_lol_i,
  output logic lock_q_o,
  output logic hw_loss_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q_o <= 1'b0;
    else         lock_q_o <= pll_lock_i;
  end
  assign hw_loss_o = lock_q_o & ~pll_lock_i & ~sw_lol_i;
endmodule

// File: rtl/ccr_rst_req.sv
module ccr_rst_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic dbg_en_i,
  input  logic hw_loss_i,
  input  logic lol_en_i,
  input  logic chkstop_i,
  input  logic cs_en_i,
  output logic hrst_req_o
);
  logic por_pend_q, dbg_q, cs_trig;

  // debug enable is captured on the first cycle after power-on and during hard reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_pend_q <= 1'b1;
      dbg_q      <= 1'b0;
    end else begin
      por_pend_q <= 1'b0;
      if (por_pend_q || hard_rst_i) dbg_q <= dbg_en_i;
    end
  end

  assign cs_trig = chkstop_i & cs_en_i & ~dbg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hrst_req_o <= 1'b0;
    else if (hard_rst_i) hrst_req_o <= 1'b0;
    else                 hrst_req_o <= (hw_loss_i & lol_en_i) | cs_trig;
  end

  assert_dbg_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chkstop_i && dbg_q && !(hw_loss_i && lol_en_i)) |=> !hrst_req_o);
  assert_lol_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_loss_i && lol_en_i && !hard_rst_i) |=> hrst_req_o);
endmodule

// File: rtl/ccr_ctrl_reg.sv
module ccr_ctrl_reg
  import ccr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NT = NUM_TMR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hard_rst_i,
  input  logic          soft_rst_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          pll_lock_i,
  input  logic          sw_lol_i,
  input  logic [NT-1:0] tmr_exp_i,
  input  logic [NT-1:0] tmr_irq_i,
  input  logic          chkstop_i,
  input  logic          dbg_en_i,
  output logic          div_sel_o,
  output logic          pwr_sw_o,
  output logic          hrst_req_o
);
  logic lock_q, hw_loss;
  logic [NUM_STAT-1:0] stat_set, stat_clr, stat_q;
  logic       csrc_q, mlock_q, cs_en_q, cs_done_q, lol_en_q;
  logic [1:0] mode_q;
  logic       soft_any;

  assign soft_any = soft_rst_i | hard_rst_i;

  ccr_lock_mon u_lock (
    .clk_i, .rst_ni, .pll_lock_i, .sw_lol_i,
    .lock_q_o (lock_q), .hw_loss_o (hw_loss)
  );

  assign stat_set = {|tmr_irq_i, |tmr_exp_i, hw_loss};
  assign stat_clr = {NUM_STAT{wr_en_i}} & {wr_data_i[B_TIRQ], wr_data_i[B_WAKE], wr_data_i[B_LOST]};

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_stat
    ccr_w1c_bit #(.RST_VAL(STAT_RST_VAL[g]), .HARD_DOM(STAT_HARD[g])) u_bit (
      .clk_i, .rst_ni, .hard_rst_i,
      .set_i (stat_set[g]), .clr_i (stat_clr[g]), .q_o (stat_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || hard_rst_i) begin
      csrc_q   <= 1'b0;
      mode_q   <= 2'b00;
      mlock_q  <= 1'b0;
      lol_en_q <= 1'b0;
    end else if (wr_en_i) begin
      lol_en_q <= wr_data_i[B_LOLEN];
      if (wr_data_i[B_LOCK]) mlock_q <= 1'b1;
      if (!mlock_q) begin
        csrc_q <= wr_data_i[B_CSRC];
        mode_q <= wr_data_i[B_MODE +: 2];
      end
    end
  end

  // checkstop enable: one write per soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || soft_any) begin
      cs_en_q   <= 1'b0;
      cs_done_q <= 1'b0;
    end else if (wr_en_i && !cs_done_q) begin
      cs_en_q   <= wr_data_i[B_CSEN];
      cs_done_q <= 1'b1;
    end
  end

  ccr_rst_req u_rreq (
    .clk_i, .rst_ni, .hard_rst_i, .dbg_en_i,
    .hw_loss_i (hw_loss), .lol_en_i (lol_en_q),
    .chkstop_i, .cs_en_i (cs_en_q), .hrst_req_o
  );

  assign div_sel_o = csrc_q & ~stat_q[2];
  assign pwr_sw_o  = (mode_q == MODE_DEEP && !csrc_q) ? stat_q[1] : 1'b1;

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[B_LIVE]     = lock_q;
    rd_data_o[B_LOST]     = stat_q[0];
    rd_data_o[B_WAKE]     = stat_q[1];
    rd_data_o[B_TIRQ]     = stat_q[2];
    rd_data_o[B_CSRC]     = csrc_q;
    rd_data_o[B_MODE +: 2] = mode_q;
    rd_data_o[B_LOCK]     = mlock_q;
    rd_data_o[B_CSEN]     = cs_en_q;
    rd_data_o[B_LOLEN]    = lol_en_q;
  end

  assert_lost_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[0] && !(wr_en_i && wr_data_i[B_LOST])) |=> stat_q[0]);
  assert_wake_hard_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> pwr_sw_o && rd_data_o[B_WAKE]);
  assert_irq_hold_div_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tmr_irq_i) |=> !div_sel_o);
  assert_lock_prot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mlock_q && !hard_rst_i) |=> ($stable(mode_q) && $stable(csrc_q) && mlock_q));
  assert_cs_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_done_q && !soft_any) |=> $stable(cs_en_q));
  assert_hard_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> !div_sel_o && !hrst_req_o);
endmodule

// File: tb/ccr_ctrl_reg_tb_top.sv
module ccr_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hard_rst = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic        pll_lock = 1'b0, sw_lol = 1'b0, chkstop = 1'b0, dbg_en = 1'b0;
  logic [3:0]  tmr_exp = '0, tmr_irq = '0;
  logic        div_sel, pwr_sw, hrst_req;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ccr_ctrl_reg dut_i (
    .clk_i (clk), .rst_ni (rst_n), .hard_rst_i (hard_rst), .soft_rst_i (soft_rst),
    .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_data_o (rd_data),
    .pll_lock_i (pll_lock), .sw_lol_i (sw_lol), .tmr_exp_i (tmr_exp), .tmr_irq_i (tmr_irq),
    .chkstop_i (chkstop), .dbg_en_i (dbg_en),
    .div_sel_o (div_sel), .pwr_sw_o (pwr_sw), .hrst_req_o (hrst_req)
  );

  typedef struct packed {
    logic       wr;
    logic [9:0] wd;
    logic       lock;
    logic       swl;
    logic [3:0] texp;
    logic [3:0] tirq;
    logic       cs;
    logic [9:0] rd;
    logic       div;
    logic       pwr;
    logic       hrst;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'h000, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h005, 1'b0, 1'b1, 1'b0}, // R1 live
    '{1'b1, 10'h310, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h315, 1'b1, 1'b1, 1'b0}, // R7 low div
    '{1'b1, 10'h314, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h311, 1'b1, 1'b1, 1'b0}, // R4 clear
    '{1'b0, 10'h000, 1'b1, 1'b0, 4'h0, 4'h1, 1'b0, 10'h319, 1'b0, 1'b1, 1'b0}, // R6 R7
    '{1'b1, 10'h318, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h311, 1'b1, 1'b1, 1'b0}, // R6 clear
    '{1'b0, 10'h000, 1'b1, 1'b0, 4'h4, 4'h0, 1'b0, 10'h315, 1'b1, 1'b1, 1'b0}, // R4 set
    '{1'b1, 10'h374, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h371, 1'b1, 1'b1, 1'b0}, // R5 csrc=1
    '{1'b1, 10'h364, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h361, 1'b0, 1'b0, 1'b0}, // R5 off
    '{1'b0, 10'h000, 1'b1, 1'b0, 4'h8, 4'h0, 1'b0, 10'h365, 1'b0, 1'b1, 1'b0}, // R5 on
    '{1'b1, 10'h3A4, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h3A1, 1'b0, 1'b1, 1'b0}, // R11 set
    '{1'b1, 10'h2F0, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h3A1, 1'b0, 1'b1, 1'b0}, // R11 R9
    '{1'b0, 10'h000, 1'b0, 1'b1, 4'h0, 4'h0, 1'b0, 10'h3A0, 1'b0, 1'b1, 1'b0}, // R2 sw
    '{1'b0, 10'h000, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h3A1, 1'b0, 1'b1, 1'b0}, // R1
    '{1'b0, 10'h000, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 10'h3A2, 1'b0, 1'b1, 1'b1}, // R2 R10
    '{1'b0, 10'h000, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 10'h3A2, 1'b0, 1'b1, 1'b0}, // R10 pulse
    '{1'b1, 10'h282, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h3A1, 1'b0, 1'b1, 1'b0}, // R3 clear
    '{1'b0, 10'h000, 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 10'h3A1, 1'b0, 1'b1, 1'b1}, // R9 cs
    '{1'b1, 10'h080, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h1A1, 1'b0, 1'b1, 1'b0}, // R10 off
    '{1'b0, 10'h000, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 10'h1A2, 1'b0, 1'b1, 1'b0}, // R10 no req
    '{1'b0, 10'h000, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 10'h1A3, 1'b0, 1'b1, 1'b0}, // R1
    '{1'b1, 10'h082, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 10'h1A2, 1'b0, 1'b1, 1'b0}, // R3 set wins
    '{1'b1, 10'h080, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 10'h1A2, 1'b0, 1'b1, 1'b0}, // R3 w0
    '{1'b1, 10'h088, 1'b0, 1'b0, 4'h0, 4'h2, 1'b0, 10'h1AA, 1'b0, 1'b1, 1'b0}  // R6 set wins
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_data = '0; sw_lol = 1'b0; tmr_exp = '0; tmr_irq = '0; chkstop = 1'b0;
    hard_rst = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    idle(); wr_en = 1'b1; wr_data = d; step(); idle();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset", rd_data, 32'h004);
    check("R5 reset pwr", {31'b0, pwr_sw}, 32'h1);
    check("R10 reset req", {31'b0, hrst_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i].wr; wr_data = {22'b0, VEC[i].wd};
      pll_lock = VEC[i].lock; sw_lol = VEC[i].swl;
      tmr_exp = VEC[i].texp; tmr_irq = VEC[i].tirq; chkstop = VEC[i].cs;
      step();
      check($sformatf("R1-vector row %0d rd", i), rd_data, {22'b0, VEC[i].rd});
      check($sformatf("R7 row %0d div", i), {31'b0, div_sel}, {31'b0, VEC[i].div});
      check($sformatf("R5 row %0d pwr", i), {31'b0, pwr_sw}, {31'b0, VEC[i].pwr});
      check($sformatf("R10 row %0d req", i), {31'b0, hrst_req}, {31'b0, VEC[i].hrst});
    end
    idle();

    // hard reset: lost kept, wake set, control fields cleared (R3 R4 R8)
    pll_lock = 1'b0; hard_rst = 1'b1; step(); idle();
    check("R8 hard reset rd", rd_data, 32'h006);
    check("R8 hard reset div", {31'b0, div_sel}, 32'h0);

    wr(32'h100);
    check("R9 first write", rd_data, 32'h106);
    wr(32'h000);
    check("R9 second write ignored", rd_data, 32'h106);
    chkstop = 1'b1; step(); idle();
    check("R9 checkstop req", {31'b0, hrst_req}, 32'h1);

    soft_rst = 1'b1; step(); idle();
    check("R9 soft reset clears", rd_data, 32'h006);
    wr(32'h104);
    check("R9 write after soft", rd_data, 32'h102);

    // debug captured at hard reset blocks checkstop request
    dbg_en = 1'b1; hard_rst = 1'b1; step(); idle(); dbg_en = 1'b0;
    wr(32'h100);
    chkstop = 1'b1; step(); idle();
    check("R9 debug blocks req", {31'b0, hrst_req}, 32'h0);

    // power-on clears sticky loss
    rst_n = 1'b0; step(); rst_n = 1'b1; @(negedge clk);
    check("R3 power-on clears lost", rd_data, 32'h004);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule